// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block takes the pixel bus of a parallel image sensor (a data bus of up to 20 bits, a frame strobe, a line strobe and a pixel clock) and turns it into a stream of tagged pixel words on a valid/ready output. All sensor pins are brought into the system clock domain through a two-flop synchronizer. The system clock must run at least four times faster than the pixel clock. Frame-strobe, line-strobe and pixel-clock transitions are found by comparing consecutive synchronized samples. The data bus is delayed by the same two stages, so each captured word matches the pixel-clock edge that selected it.

Two capture modes exist. In gated mode, a pixel clock edge counts only while the line strobe is at its active level. In non-gated mode the line strobe is ignored and every capture edge after a frame start yields a word. Each word is tagged: the first word of a frame carries a start-of-frame flag, and the last word of a line carries an end-of-line flag. The end-of-line flag comes from a one-word holding stage that is released when the line ends or the next frame begins. Words then go into an 8-entry FIFO. A word that arrives while the FIFO is full is lost and raises a sticky overflow flag.

Top module: `cam_capture`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `overflow` are 0.
- R2: After reset, no word is produced until the first frame trigger; pixel clock edges before it are discarded.
- R3: The frame trigger is a rising transition of `sen_frame` when `cfg_frame_fall`=0 and a falling one when it is 1; this bit is applied live, not latched.
- R4: In gated mode (`cfg_gated`=1) a capture edge counts only while `sen_line` is at its active level (high when `cfg_line_low`=0, low when 1); edges while the line is inactive produce no word.
- R5: A word is captured on the rising edge of `sen_pclk` when `cfg_pclk_fall`=0, on the falling edge when 1, and `out_data` equals the value `sen_data` held at that edge.
- R6: In non-gated mode (`cfg_gated`=0) `sen_line` has no effect and every capture edge after a frame trigger produces one word.
- R7: `out_sof` is 1 on the first word captured after a frame trigger and 0 on every other word.
- R8: In gated mode `out_eol` is 1 on the last word before the line strobe goes inactive. In both modes, a word still held when the next frame trigger arrives leaves with `out_eol`=1. All other words carry `out_eol`=0.
- R9: `cfg_gated`, `cfg_line_low` and `cfg_pclk_fall` are sampled at a frame trigger; changes in mid-frame do not affect the current frame.
- R10: Words leave in capture order through an 8-entry FIFO. A word is transferred when `out_valid` and `out_ready` are both 1. While `out_ready` is 0 the presented word and its flags hold steady.
- R11: A word pushed while the FIFO holds 8 entries is dropped and sets `overflow`. The flag stays set until the next frame trigger clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gated | input | 1 | 1 = gated capture, 0 = non-gated capture |
| cfg_frame_fall | input | 1 | Frame trigger on falling (1) or rising (0) transition |
| cfg_line_low | input | 1 | Line strobe active low (1) or high (0) |
| cfg_pclk_fall | input | 1 | Capture on falling (1) or rising (0) pixel clock edge |
| sen_data | input | DATA_W | Sensor pixel data bus |
| sen_frame | input | 1 | Sensor frame strobe |
| sen_line | input | 1 | Sensor line strobe |
| sen_pclk | input | 1 | Sensor pixel clock |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | DATA_W | Captured pixel value |
| out_sof | output | 1 | Word is the first of its frame |
| out_eol | output | 1 | Word closes its line |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |

## Verification
The bench uses the default widths: a 20-bit bus and an 8-entry FIFO. With a FIFO that shallow, a single ten-pixel line with the output stalled is enough to fill it, drop a word and raise the flag. The four configuration bits give only sixteen combinations, so the bench runs one complete frame in every combination. The frame size differs from one combination to the next, and each expected word is computed from its frame, line and pixel indices.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int unsigned SENSOR_W    = 20;
    localparam int unsigned SYNC_STAGES = 2;

    // Settings captured at each frame trigger.
    typedef struct packed {
        logic gated;
        logic line_low;
        logic pclk_fall;
    } cam_mode_t;

    typedef struct packed {
        logic sof;
        logic eol;
    } cam_tag_t;

    localparam int unsigned TAG_W = $bits(cam_tag_t);

    function automatic logic edge_seen(input logic prev, input logic cur, input logic on_fall);
        return on_fall ? (prev & ~cur) : (~prev & cur);
    endfunction

    function automatic logic level_on(input logic pin, input logic active_low);
        return pin ^ active_low;
    endfunction

endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/cam_frontend.sv
module cam_frontend
    import cam_pkg::*;
#(
    parameter int unsigned DATA_W = SENSOR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cam_mode_t         mode_next,
    input  logic              frame_fall,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_frame,
    input  logic              s_line,
    input  logic              s_pclk,
    output logic              frame_trig,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output cam_tag_t          push_tag
);
    logic              frame_q, line_q, pclk_q;
    cam_mode_t         mode_r;
    logic              armed, sof_pend;
    logic              hold_v, hold_sof;
    logic [DATA_W-1:0] hold_data;
    logic              line_now, line_end, pix_hit, flush;

    assign frame_trig = edge_seen(frame_q, s_frame, frame_fall);
    assign line_now   = level_on(s_line, mode_r.line_low);
    assign line_end   = mode_r.gated && level_on(line_q, mode_r.line_low) && !line_now;
    assign pix_hit    = armed && !frame_trig
                     && edge_seen(pclk_q, s_pclk, mode_r.pclk_fall)
                     && (!mode_r.gated || line_now);
    assign flush      = hold_v && (frame_trig || line_end);

    // One push per cycle at most: a flush and a new pixel never coincide.
    assign push         = flush || (pix_hit && hold_v);
    assign push_data    = hold_data;
    assign push_tag.sof = hold_sof;
    assign push_tag.eol = flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= 1'b0;
            line_q    <= 1'b0;
            pclk_q    <= 1'b0;
            mode_r    <= '0;
            armed     <= 1'b0;
            sof_pend  <= 1'b0;
            hold_v    <= 1'b0;
            hold_sof  <= 1'b0;
            hold_data <= '0;
        end else begin
            frame_q <= s_frame;
            line_q  <= s_line;
            pclk_q  <= s_pclk;
            if (frame_trig) begin
                armed    <= 1'b1;
                sof_pend <= 1'b1;
                mode_r   <= mode_next;
            end
            if (flush) hold_v <= 1'b0;
            if (pix_hit) begin
                hold_v    <= 1'b1;
                hold_data <= s_data;
                hold_sof  <= sof_pend;
                sof_pend  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
    parameter int unsigned W     = 22,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_word,
    output logic          full,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [W-1:0]  rd_word,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          accept, take;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign accept   = wr_en && !full;
    assign take     = rd_valid && rd_ready;
    assign rd_word  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (take)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(accept) - CW'(take);
        end
    end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_pkg::*;
#(
    parameter int unsigned DATA_W     = SENSOR_W,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned WORD_W    = DATA_W + TAG_W,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_gated,
    input  logic              cfg_frame_fall,
    input  logic              cfg_line_low,
    input  logic              cfg_pclk_fall,
    input  logic [DATA_W-1:0] sen_data,
    input  logic              sen_frame,
    input  logic              sen_line,
    input  logic              sen_pclk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eol,
    output logic              overflow
);
    logic [2:0]        ctl_sync;
    logic [DATA_W-1:0] data_sync;
    logic              frame_trig, push, fifo_full;
    logic [DATA_W-1:0] push_data;
    cam_tag_t          push_tag, out_tag;
    cam_mode_t         mode_next;
    logic [WORD_W-1:0] rd_word;
    logic [CNT_W-1:0]  fifo_count;

    assign mode_next = '{gated: cfg_gated, line_low: cfg_line_low, pclk_fall: cfg_pclk_fall};

    cam_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(clk), .rst(rst),
        .d({sen_frame, sen_line, sen_pclk}), .q(ctl_sync)
    );

    cam_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk(clk), .rst(rst), .d(sen_data), .q(data_sync)
    );

    cam_frontend #(.DATA_W(DATA_W)) u_front (
        .clk(clk), .rst(rst),
        .mode_next(mode_next), .frame_fall(cfg_frame_fall),
        .s_data(data_sync), .s_frame(ctl_sync[2]), .s_line(ctl_sync[1]), .s_pclk(ctl_sync[0]),
        .frame_trig(frame_trig), .push(push), .push_data(push_data), .push_tag(push_tag)
    );

    cam_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(push), .wr_word({push_tag, push_data}), .full(fifo_full),
        .rd_valid(out_valid), .rd_ready(out_ready), .rd_word(rd_word), .count(fifo_count)
    );

    assign out_tag  = cam_tag_t'(rd_word[WORD_W-1 -: TAG_W]);
    assign out_data = rd_word[DATA_W-1:0];
    assign out_sof  = out_tag.sof;
    assign out_eol  = out_tag.eol;

    always_ff @(posedge clk) begin
        if (rst)                    overflow <= 1'b0;
        else if (push && fifo_full) overflow <= 1'b1;
        else if (frame_trig)        overflow <= 1'b0;
    end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_trig,
    input logic              push,
    input logic              fifo_full,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eol,
    input logic              overflow
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_quiet_r1: assert (!out_valid && !overflow)
                else $error("reset state not quiet");
        end
    end

    p_hold_while_stalled_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));

    p_drain_counts_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !(push && !fifo_full) |=> fifo_count == $past(fifo_count) - CNT_W'(1));

    p_overflow_set_r11: assert property (@(posedge clk) disable iff (rst)
        push && fifo_full |=> overflow);

    p_overflow_clear_r11: assert property (@(posedge clk) disable iff (rst)
        frame_trig && !(push && fifo_full) |=> !overflow);

    p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        overflow && !frame_trig |=> overflow);
endmodule

bind cam_capture cam_capture_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .frame_trig(frame_trig), .push(push), .fifo_full(fifo_full),
    .fifo_count(fifo_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .overflow(overflow)
);

// File: tb/cam_capture_bench.sv
`timescale 1ns/1ps
module cam_capture_bench;
    localparam int DW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_gated = 1'b0, cfg_frame_fall = 1'b0, cfg_line_low = 1'b0, cfg_pclk_fall = 1'b0;
    logic [DW-1:0] sen_data = '0;
    logic          sen_frame = 1'b0, sen_line = 1'b0, sen_pclk = 1'b0;
    logic          out_valid, out_ready = 1'b0, out_sof, out_eol, overflow;
    logic [DW-1:0] out_data;

    int checks = 0, errors = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R10";

    logic [DW+1:0] exp_q [2048];
    int exp_wr = 0, exp_rd = 0;

    always #4 clk = ~clk;

    cam_capture u_cam_capture (
        .clk(clk), .rst(rst),
        .cfg_gated(cfg_gated), .cfg_frame_fall(cfg_frame_fall),
        .cfg_line_low(cfg_line_low), .cfg_pclk_fall(cfg_pclk_fall),
        .sen_data(sen_data), .sen_frame(sen_frame), .sen_line(sen_line), .sen_pclk(sen_pclk),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_word(input logic sof, input logic eol, input logic [DW-1:0] d);
        exp_q[exp_wr] = {sof, eol, d};
        exp_wr++;
    endtask

    function automatic logic [DW-1:0] mk(input int c, input int l, input int p);
        return DW'((c * 4099 + l * 257 + p * 31 + 7) ^ (c << 15));
    endfunction

    task automatic pix(input logic [DW-1:0] d, input logic fall, input bit tog_line);
        sen_data = d;
        if (tog_line) sen_line = ~sen_line;
        tick(3);
        sen_pclk = ~fall;
        tick(4);
        sen_pclk = fall;
        tick(2);
    endtask

    task automatic trigger(input logic fall);
        sen_frame = fall;
        tick(5);
        sen_frame = ~fall;
        tick(6);
    endtask

    // Ready pattern driver.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (ready_mode)
                0:       out_ready = 1'b0;
                1:       out_ready = 1'b1;
                default: out_ready = (cyc % 3) != 0;
            endcase
        end
    end

    // Output monitor: compares every transferred word in order (R10, R5, R7, R8).
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_rd >= exp_wr) begin
                check(1'b0, {cur_req, " unexpected word"}, {10'd0, out_sof, out_eol, out_data}, 32'd0);
            end else begin
                check({out_sof, out_eol, out_data} == exp_q[exp_rd], cur_req,
                      {10'd0, out_sof, out_eol, out_data}, {10'd0, exp_q[exp_rd]});
                exp_rd++;
            end
        end
    end

    task automatic run_cfg(input int c);
        logic g, ff, ll, pf;
        int npix;
        g = c[0]; ff = c[1]; ll = c[2]; pf = c[3];
        npix = 3 + (c % 3);
        cfg_gated = g; cfg_frame_fall = ff; cfg_line_low = ll; cfg_pclk_fall = pf;
        trigger(ff);
        sen_pclk = pf;
        sen_line = ll;
        tick(4);
        for (int l = 0; l < 3; l++) begin
            if (g) begin
                sen_line = ~ll;
                tick(4);
                for (int p = 0; p < npix; p++) begin
                    expect_word(l == 0 && p == 0, p == npix - 1, mk(c, l, p));
                    pix(mk(c, l, p), pf, 1'b0);
                end
                sen_line = ll;
                tick(6);
                // R4: edges while the line is inactive must be ignored.
                pix(20'hFFFFF, pf, 1'b0);
                pix(20'hAAAAA, pf, 1'b0);
            end else begin
                // R6: line strobe toggles freely and is ignored.
                for (int p = 0; p < npix; p++) begin
                    expect_word(l == 0 && p == 0, l == 2 && p == npix - 1, mk(c, l, p));
                    pix(mk(c, l, p), pf, 1'b1);
                end
            end
            tick(4);
        end
    endtask

    initial begin
        tick(5);
        check(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 0);
        check(overflow == 1'b0, "R1 overflow in reset", 32'(overflow), 0);
        rst = 1'b0;
        tick(1);
        check(out_valid == 1'b0 && overflow == 1'b0, "R1 after reset", {out_valid, overflow}, 0);

        // R2: pixels before any frame trigger are discarded.
        cur_req = "R2";
        ready_mode = 1;
        for (int p = 0; p < 3; p++) pix(DW'(p + 5), 1'b0, 1'b1);
        tick(10);
        check(out_valid == 1'b0, "R2 no word before frame", 32'(out_valid), 0);

        // R11: overflow with a stalled output, non-gated rising edges.
        cur_req = "R11 R10";
        ready_mode = 0;
        tick(2);
        trigger(1'b0);
        for (int p = 0; p < 10; p++) begin
            if (p < 8) expect_word(p == 0, 1'b0, DW'(32'h100 + p));
            pix(DW'(32'h100 + p), 1'b0, 1'b1);
        end
        tick(6);
        check(overflow == 1'b1, "R11 overflow set", 32'(overflow), 1);
        check(out_valid == 1'b1, "R10 fifo holds words", 32'(out_valid), 1);
        ready_mode = 1;
        tick(20);
        check(out_valid == 1'b0, "R11 dropped word absent", 32'(out_valid), 0);
        check(exp_rd == 8, "R10 eight words drained", 32'(exp_rd), 8);
        check(overflow == 1'b1, "R11 overflow sticky", 32'(overflow), 1);
        expect_word(1'b0, 1'b1, DW'(32'h109));
        trigger(1'b0);
        tick(4);
        check(overflow == 1'b0, "R11 cleared by frame trigger", 32'(overflow), 0);
        tick(6);
        check(exp_rd == exp_wr, "R8 held word flushed at frame", 32'(exp_rd), 32'(exp_wr));

        // Exhaustive sweep over all mode/polarity combinations.
        cur_req = "R3 R4 R5 R6 R7 R8";
        ready_mode = 2;
        for (int c = 0; c < 16; c++) run_cfg(c);

        // R9: mid-frame configuration change has no effect on the current frame.
        cur_req = "R9";
        cfg_gated = 1'b1; cfg_frame_fall = 1'b0; cfg_line_low = 1'b0; cfg_pclk_fall = 1'b0;
        trigger(1'b0);
        sen_pclk = 1'b0;
        sen_line = 1'b0;
        tick(4);
        for (int l = 0; l < 2; l++) begin
            if (l == 1) begin
                cfg_gated = 1'b0; cfg_line_low = 1'b1; cfg_pclk_fall = 1'b1;
            end
            sen_line = 1'b1;
            tick(4);
            for (int p = 0; p < 2; p++) begin
                expect_word(l == 0 && p == 0, p == 1, mk(20, l, p));
                pix(mk(20, l, p), 1'b0, 1'b0);
            end
            sen_line = 1'b0;
            tick(6);
            pix(20'h12345, 1'b0, 1'b0);
        end
        cfg_gated = 1'b0; cfg_line_low = 1'b0; cfg_pclk_fall = 1'b0;
        trigger(1'b0);
        tick(40);
        check(exp_rd == exp_wr, "R10 all words delivered in order", 32'(exp_rd), 32'(exp_wr));
        check(overflow == 1'b0, "R11 no overflow during sweep", 32'(overflow), 0);
        check(out_valid == 1'b0, "R10 fifo empty at end", 32'(out_valid), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule